// File: doc/BRIEF.md
# Row Steering Sequencer with Cascade Handoff

This block drives the row-select and charge-clear lines of a pixel matrix that is read one row at a time. For every row it runs three timed phases. First the row is selected so the readout side can sample the filled cells. Then the row is deselected and its clear line is pulsed to empty the in-pixel charge stores. Finally the row is selected again so the emptied cells can be sampled. A single all-low cycle separates one row from the next. The length of each phase is set in clock cycles by three small pattern registers.

A sample strobe marks the last cycle of each selected phase. It carries a tag and the row index, so the readout side can subtract the empty sample from the filled one. One instance owns a parameterised number of rows, 64 by default. Longer columns are covered by chaining instances. When the last row of an instance completes, the instance emits a one-cycle token and returns to idle. The next instance accepts that token as its start. A synchronous abort puts the instance back to idle at once, with every line released.

Top module: `row_steer_seq`

## Requirements
- R1: During reset and while idle, all gate and clear lines, the sample strobe and the token output are low.
- R2: A start pulse sampled while idle begins a frame at row 0. The gate line of row 0 goes high in the second cycle after the edge that sampled the start.
- R3: Each row shows its gate line high for the fill length, then its clear line high for the clear length, then its gate line high for the empty length. Each length is in clock cycles.
- R4: A programmed length of 0 acts as a length of 1.
- R5: No cycle has more than one gate or clear line high, and a gate and a clear line are never high together.
- R6: Rows are visited in ascending order. Exactly one cycle with all lines low separates the end of one row from the start of the next.
- R7: The sample strobe is high for exactly the last cycle of each gate phase. Its tag is 0 for the filled sample and 1 for the empty sample, and its row output gives the row being sampled.
- R8: After the last row, the token output is high for one cycle, which is the all-low cycle following that row. The block is then idle and will accept a new start.
- R9: A token-in pulse sampled while idle starts a frame exactly as a start pulse does.
- R10: Start and token-in pulses that arrive during a frame have no effect on the running frame.
- R11: When abort is sampled, all lines, the strobe and the token output are low from the next cycle, and the block is idle. A start sampled together with abort is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (50 MHz target) |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a frame when idle |
| abort_i | input | 1 | Synchronous abort to idle |
| tok_i | input | 1 | Cascade token from the preceding instance |
| len_fill_i | input | DUR_W | Filled-sample phase length in cycles |
| len_clr_i | input | DUR_W | Clear phase length in cycles |
| len_empty_i | input | DUR_W | Empty-sample phase length in cycles |
| gate_o | output | ROWS | One-hot row select lines |
| clear_o | output | ROWS | One-hot row clear lines |
| smp_vld_o | output | 1 | Sample strobe to the readout side |
| smp_tag_o | output | 1 | 0 = filled sample, 1 = empty sample |
| smp_row_o | output | ROW_W | Row index of the current sample |
| tok_o | output | 1 | Cascade token to the following instance |

## Verification
The hardest situations to reach from the ports are the handoffs at the ends of a frame. One is the token cycle after the final row, followed at once by a restart through token-in. The other is an abort that lands in the middle of a phase. The bench builds the instance with only four rows, so every frame quickly reaches the last-row token. It runs frames back to back, starts one frame through token-in, and asserts abort in the middle of a clear phase and also together with a start. Extra start and token pulses are injected in the middle of a frame, and the expected cycle stream is left unchanged.

// File: rtl/rss_pkg.sv
package rss_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_FILL  = 3'd1,
    PH_CLR   = 3'd2,
    PH_EMPTY = 3'd3,
    PH_GAP   = 3'd4
  } phase_e;
endpackage

// File: rtl/rss_phase_fsm.sv
module rss_phase_fsm
  import rss_pkg::*;
#(
  parameter int DUR_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             abort_i,
  input  logic             launch_i,
  input  logic             last_row_i,
  input  logic [DUR_W-1:0] len_fill_i,
  input  logic [DUR_W-1:0] len_clr_i,
  input  logic [DUR_W-1:0] len_empty_i,
  output phase_e           phase_o,
  output logic             dwell_end_o,
  output logic             adv_o,
  output logic             finish_o
);
  phase_e           phase_q;
  logic [DUR_W-1:0] cnt_q;

  // Reload value: length minus one, with zero treated as one cycle.
  function automatic logic [DUR_W-1:0] reload(input logic [DUR_W-1:0] len);
    return (len == '0) ? '0 : len - 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst || abort_i) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: if (launch_i) begin
          phase_q <= PH_FILL;
          cnt_q   <= reload(len_fill_i);
        end
        PH_FILL: if (cnt_q == '0) begin
          phase_q <= PH_CLR;
          cnt_q   <= reload(len_clr_i);
        end else cnt_q <= cnt_q - 1'b1;
        PH_CLR: if (cnt_q == '0) begin
          phase_q <= PH_EMPTY;
          cnt_q   <= reload(len_empty_i);
        end else cnt_q <= cnt_q - 1'b1;
        PH_EMPTY: if (cnt_q == '0) begin
          phase_q <= PH_GAP;
          cnt_q   <= '0;
        end else cnt_q <= cnt_q - 1'b1;
        PH_GAP: begin
          phase_q <= last_row_i ? PH_IDLE : PH_FILL;
          cnt_q   <= reload(len_fill_i);
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o     = phase_q;
  assign dwell_end_o = (cnt_q == '0);
  assign adv_o       = (phase_q == PH_GAP) && !last_row_i;
  assign finish_o    = (phase_q == PH_GAP) && last_row_i;

  // R3: phase order fill -> clear -> empty -> gap
  a_r3_fill_to_clr: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_FILL && cnt_q == '0 && !abort_i) |=> (phase_q == PH_CLR));
  a_r3_clr_to_empty: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_CLR && cnt_q == '0 && !abort_i) |=> (phase_q == PH_EMPTY));
  // R6: gap lasts exactly one cycle
  a_r6_gap_single: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_GAP) |=> (phase_q != PH_GAP));
  // R11: abort always returns to idle
  a_r11_abort_idle: assert property (@(posedge clk) disable iff (rst)
    abort_i |=> (phase_q == PH_IDLE));
endmodule

// File: rtl/rss_row_ptr.sv
module rss_row_ptr #(
  parameter int ROWS  = 64,
  parameter int ROW_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             abort_i,
  input  logic             launch_i,
  input  logic             adv_i,
  output logic [ROW_W-1:0] row_o,
  output logic             last_o
);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk) begin
    if (rst || abort_i || launch_i) row_q <= '0;
    else if (adv_i)                 row_q <= row_q + 1'b1;
  end

  assign row_o  = row_q;
  assign last_o = (row_q == LAST_ROW);

  // R6: ascending row order
  a_r6_row_step: assert property (@(posedge clk) disable iff (rst)
    (adv_i && !abort_i && !launch_i) |=> (row_q == $past(row_q) + 1'b1));
  a_r6_row_range: assert property (@(posedge clk) disable iff (rst)
    (row_q <= LAST_ROW));
endmodule

// File: rtl/rss_line_drv.sv
module rss_line_drv
  import rss_pkg::*;
#(
  parameter int ROWS  = 64,
  parameter int ROW_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             abort_i,
  input  phase_e           phase_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic             dwell_end_i,
  input  logic             finish_i,
  output logic [ROWS-1:0]  gate_o,
  output logic [ROWS-1:0]  clear_o,
  output logic             smp_vld_o,
  output logic             smp_tag_o,
  output logic [ROW_W-1:0] smp_row_o,
  output logic             tok_o
);
  logic sel_gate, sel_clr;

  assign sel_gate = (phase_i == PH_FILL) || (phase_i == PH_EMPTY);
  assign sel_clr  = (phase_i == PH_CLR);

  for (genvar i = 0; i < ROWS; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst || abort_i) begin
        gate_o[i]  <= 1'b0;
        clear_o[i] <= 1'b0;
      end else begin
        gate_o[i]  <= sel_gate && (row_i == ROW_W'(i));
        clear_o[i] <= sel_clr  && (row_i == ROW_W'(i));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || abort_i) begin
      smp_vld_o <= 1'b0;
      smp_tag_o <= 1'b0;
      smp_row_o <= '0;
      tok_o     <= 1'b0;
    end else begin
      smp_vld_o <= sel_gate && dwell_end_i;
      smp_tag_o <= (phase_i == PH_EMPTY);
      smp_row_o <= row_i;
      tok_o     <= finish_i;
    end
  end

  // R5: at most one line, never gate and clear together
  a_r5_one_line: assert property (@(posedge clk) disable iff (rst)
    $onehot0({gate_o, clear_o}));
  // R6: a selected row stays the same row while continuously selected
  a_r6_hold_row: assert property (@(posedge clk) disable iff (rst)
    ((|gate_o) && $past(|gate_o)) |-> (gate_o == $past(gate_o)));
  // R7: strobe only while a row is selected
  a_r7_strobe_gated: assert property (@(posedge clk) disable iff (rst)
    smp_vld_o |-> (|gate_o));
  // R8: token is a single-cycle pulse with all lines low
  a_r8_tok_single: assert property (@(posedge clk) disable iff (rst)
    tok_o |=> !tok_o);
  a_r8_tok_quiet: assert property (@(posedge clk) disable iff (rst)
    tok_o |-> (gate_o == '0 && clear_o == '0));
  // R11: abort silences every output on the next cycle
  a_r11_abort_quiet: assert property (@(posedge clk) disable iff (rst)
    abort_i |=> (gate_o == '0 && clear_o == '0 && !smp_vld_o && !tok_o));
endmodule

// File: rtl/row_steer_seq.sv
module row_steer_seq
  import rss_pkg::*;
#(
  parameter int ROWS  = 64,
  parameter int DUR_W = 4,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic             tok_i,
  input  logic [DUR_W-1:0] len_fill_i,
  input  logic [DUR_W-1:0] len_clr_i,
  input  logic [DUR_W-1:0] len_empty_i,
  output logic [ROWS-1:0]  gate_o,
  output logic [ROWS-1:0]  clear_o,
  output logic             smp_vld_o,
  output logic             smp_tag_o,
  output logic [ROW_W-1:0] smp_row_o,
  output logic             tok_o
);
  phase_e           phase;
  logic             dwell_end, adv, finish, last_row, launch;
  logic [ROW_W-1:0] row;

  // Start and token-in are only heard while idle; abort wins.
  assign launch = (phase == PH_IDLE) && (start_i || tok_i) && !abort_i;

  rss_phase_fsm #(.DUR_W(DUR_W)) u_fsm (
    .clk(clk), .rst(rst), .abort_i(abort_i), .launch_i(launch),
    .last_row_i(last_row), .len_fill_i(len_fill_i), .len_clr_i(len_clr_i),
    .len_empty_i(len_empty_i), .phase_o(phase), .dwell_end_o(dwell_end),
    .adv_o(adv), .finish_o(finish)
  );

  rss_row_ptr #(.ROWS(ROWS), .ROW_W(ROW_W)) u_row (
    .clk(clk), .rst(rst), .abort_i(abort_i), .launch_i(launch),
    .adv_i(adv), .row_o(row), .last_o(last_row)
  );

  rss_line_drv #(.ROWS(ROWS), .ROW_W(ROW_W)) u_drv (
    .clk(clk), .rst(rst), .abort_i(abort_i), .phase_i(phase), .row_i(row),
    .dwell_end_i(dwell_end), .finish_i(finish), .gate_o(gate_o),
    .clear_o(clear_o), .smp_vld_o(smp_vld_o), .smp_tag_o(smp_tag_o),
    .smp_row_o(smp_row_o), .tok_o(tok_o)
  );

  // R10: a busy frame is not restarted by start or token-in
  a_r10_no_restart: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE && phase != PH_GAP && !abort_i) |=> (phase != PH_IDLE));
endmodule

// File: tb/row_steer_seq_test.sv
module row_steer_seq_test;
  localparam int PER = 20;
  localparam int NR  = 4;
  localparam int DW  = 4;
  localparam int RW  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, abort_i = 1'b0, tok_i = 1'b0;
  logic [DW-1:0] len_fill_i = '0, len_clr_i = '0, len_empty_i = '0;
  logic [NR-1:0] gate_o, clear_o;
  logic smp_vld_o, smp_tag_o, tok_o;
  logic [RW-1:0] smp_row_o;

  typedef struct packed {
    logic [NR-1:0] g;
    logic [NR-1:0] c;
    logic          v;
    logic          t;
    logic [RW-1:0] r;
    logic          k;
  } exp_t;

  exp_t  q[$];
  int    total = 0;
  int    bad = 0;
  string ctx = "R1";

  always #(PER/2) clk = ~clk;

  row_steer_seq #(.ROWS(NR), .DUR_W(DW)) uut (
    .clk(clk), .rst(rst), .start_i(start_i), .abort_i(abort_i), .tok_i(tok_i),
    .len_fill_i(len_fill_i), .len_clr_i(len_clr_i), .len_empty_i(len_empty_i),
    .gate_o(gate_o), .clear_o(clear_o), .smp_vld_o(smp_vld_o),
    .smp_tag_o(smp_tag_o), .smp_row_o(smp_row_o), .tok_o(tok_o)
  );

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  // Driver side: expected cycle stream for one frame (R2, R3, R4, R6, R7, R8).
  task automatic push_frame(input int f, input int c, input int e);
    exp_t it;
    q.push_back('0);  // cycle after the sampling edge: outputs still low (R2)
    for (int r = 0; r < NR; r++) begin
      for (int k = 0; k < eff(f); k++) begin
        it = '0; it.g = NR'(1) << r; it.v = (k == eff(f) - 1); it.r = RW'(r);
        q.push_back(it);
      end
      for (int k = 0; k < eff(c); k++) begin
        it = '0; it.c = NR'(1) << r; q.push_back(it);
      end
      for (int k = 0; k < eff(e); k++) begin
        it = '0; it.g = NR'(1) << r; it.v = (k == eff(e) - 1); it.t = 1'b1;
        it.r = RW'(r); q.push_back(it);
      end
      it = '0; it.k = (r == NR - 1); q.push_back(it);  // gap / token (R6, R8)
    end
  endtask

  task automatic note(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s (%s) %s: actual=%0h expected=%0h", req, ctx, what, act, exp);
    end
  endtask

  // Monitor: compares every cycle after reset; empty queue means idle expected.
  always @(posedge clk) begin
    exp_t ex;
    #(PER/4);
    if (!rst) begin
      ex = (q.size() != 0) ? q.pop_front() : exp_t'('0);
      note(gate_o == ex.g, "R3", "gate", 32'(gate_o), 32'(ex.g));
      note(clear_o == ex.c, "R5", "clear", 32'(clear_o), 32'(ex.c));
      note(smp_vld_o == ex.v, "R7", "strobe", 32'(smp_vld_o), 32'(ex.v));
      if (ex.v) begin
        note(smp_tag_o == ex.t, "R7", "tag", 32'(smp_tag_o), 32'(ex.t));
        note(smp_row_o == ex.r, "R6", "row", 32'(smp_row_o), 32'(ex.r));
      end
      note(tok_o == ex.k, "R8", "token", 32'(tok_o), 32'(ex.k));
    end
  end

  task automatic cfg(input int f, input int c, input int e);
    len_fill_i = DW'(f); len_clr_i = DW'(c); len_empty_i = DW'(e);
  endtask

  task automatic kick(input bit via_tok, input int f, input int c, input int e);
    @(negedge clk);
    cfg(f, c, e);
    if (via_tok) tok_i = 1'b1; else start_i = 1'b1;
    push_frame(f, c, e);
    @(negedge clk);
    tok_i = 1'b0; start_i = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    note(gate_o == '0 && clear_o == '0, "R1", "lines in reset", 32'({gate_o, clear_o}), 0);
    note(!smp_vld_o && !tok_o, "R1", "strobe/token in reset", 32'({smp_vld_o, tok_o}), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    ctx = "R2"; kick(1'b0, 2, 3, 1); drain();
    ctx = "R3"; kick(1'b0, 1, 1, 1); drain();
    ctx = "R4"; kick(1'b0, 0, 15, 4); drain();
    ctx = "R9"; kick(1'b1, 3, 1, 2); drain();

    // R10: extra start and token-in pulses mid-frame change nothing
    ctx = "R10"; kick(1'b0, 2, 2, 2);
    repeat (6) @(negedge clk);
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    repeat (9) @(negedge clk);
    tok_i = 1'b1; @(negedge clk); tok_i = 1'b0;
    drain();

    // R11: abort in the middle of a frame
    ctx = "R11"; kick(1'b0, 3, 3, 3);
    repeat (14) @(negedge clk);
    abort_i = 1'b1; q.delete();
    @(negedge clk); abort_i = 1'b0;
    repeat (10) @(negedge clk);
    // R11: start together with abort is ignored
    abort_i = 1'b1; start_i = 1'b1;
    @(negedge clk); abort_i = 1'b0; start_i = 1'b0;
    repeat (10) @(negedge clk);
    // R8: idle again, a fresh frame runs normally
    ctx = "R8"; kick(1'b0, 1, 2, 3); drain();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog (%s): actual=timeout expected=finish", ctx);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule